// File: doc/BRIEF.md
# Interrupt Vector Resolver

This block sits behind the status registers of a 64-source interrupt controller. It takes the pending, enable and fast-type vectors held elsewhere, together with a 4-bit priority for each source packed into 32-bit priority words. From these it computes two read values. The normal vector word names the enabled, pending, non-fast source with the greatest priority. The fast vector word names the lowest-numbered enabled, pending, fast-typed source.

Both words are combinational and valid in the same cycle as the inputs that produce them. A read strobe on either word consumes the interrupt that was reported. On the clock edge that samples the strobe, the block registers a one-hot clear pulse for that source, and the pending storage uses the pulse to drop the source's pending bit. The pulse lasts exactly one cycle.

Normal candidates are compared in a balanced binary tree. At each node the higher-numbered side wins a tie, so among sources of equal priority the highest-numbered one is reported. The fast search is a simple lowest-set-bit scan.

Top module: `irq_vector_resolver`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, both clear outputs are all zero.
- R2: The priority of source n is the 4-bit field at bits 4*(n mod 8)+3 : 4*(n mod 8) of priority word n/8. Word k occupies bits 32*k+31 : 32*k of `prio_words`.
- R3: The normal word selects, among sources that are pending, enabled and not fast-typed, the one with the greatest priority. Disabled and fast-typed sources never win. The word is valid in the same cycle as its inputs.
- R4: When several normal candidates share the greatest priority, the highest-numbered of them is selected.
- R5: A valid normal word carries the source number, zero-extended, in bits 31:16. It carries the priority, zero-extended, in bits 15:0.
- R6: The fast word is the lowest-numbered source that is pending, enabled and fast-typed, zero-extended to 32 bits. It is valid in the same cycle as its inputs.
- R7: With no candidate of its kind, each word reads 0xFFFFFFFF.
- R8: A strobe on either word while that word is valid produces, in the cycle after the sampling edge, a clear output with exactly the reported source's bit set. The clear output returns to zero in the following cycle unless a new strobe was sampled.
- R9: A strobe while the word reads 0xFFFFFFFF, or no strobe at all, leaves the matching clear output all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pend | input | 64 | Pending flag per source |
| enab | input | 64 | Enable flag per source |
| fast_typ | input | 64 | 1 marks a source as fast-typed |
| prio_words | input | 256 | Eight packed priority words |
| rd_norm | input | 1 | Read strobe for the normal word |
| rd_fast | input | 1 | Read strobe for the fast word |
| norm_word | output | 32 | Normal vector and status word |
| fast_word | output | 32 | Fast vector word |
| clr_norm | output | 64 | One-cycle clear pulse from a normal read |
| clr_fast | output | 64 | One-cycle clear pulse from a fast read |

## Verification
Both vector words are combinational. The bench changes inputs on the falling edge and compares the words a short delay later, within the same cycle. The clear pulses pass through one register. A strobe raised on a falling edge is sampled at the next rising edge, so the bench checks the pulse on the falling edge after that, and checks it is gone one cycle later. After each pulse the bench drops the pending bit itself, as the storage would. Drain loops therefore show the reported order across several reads.

// File: rtl/irq_vector_pkg.sv
package irq_vector_pkg;
   localparam int unsigned STAT_W    = 32;
   localparam int unsigned IDX_LSB   = 16;
   localparam logic [STAT_W-1:0] NO_CAND = '1;
endpackage

// File: rtl/irq_prio_unpack.sv
module irq_prio_unpack #(
   parameter int unsigned NSRC   = 64,
   parameter int unsigned PRIO_W = 4,
   parameter int unsigned WORD_W = 32
) (
   input  logic [NSRC*PRIO_W-1:0]        words_flat,
   output logic [NSRC-1:0][PRIO_W-1:0]   prio
);
   localparam int unsigned PER_WORD = WORD_W / PRIO_W;

   initial begin
      assert (WORD_W % PRIO_W == 0) else $fatal(1, "word width must hold whole fields");
   end

   for (genvar s = 0; s < NSRC; s++) begin : g_src
      localparam int unsigned WI  = s / PER_WORD;
      localparam int unsigned POS = PRIO_W * (s % PER_WORD);
      assign prio[s] = words_flat[WI*WORD_W + POS +: PRIO_W];
   end
endmodule

// File: rtl/irq_prio_tree.sv
module irq_prio_tree #(
   parameter int unsigned NSRC   = 64,
   parameter int unsigned PRIO_W = 4,
   localparam int unsigned IDX_W = $clog2(NSRC),
   localparam int unsigned LVLS  = $clog2(NSRC)
) (
   input  logic [NSRC-1:0]               cand,
   input  logic [NSRC-1:0][PRIO_W-1:0]   prio,
   output logic                          hit,
   output logic [IDX_W-1:0]              win_idx,
   output logic [PRIO_W-1:0]             win_prio
);
   initial begin
      assert ((NSRC & (NSRC - 1)) == 0 && NSRC >= 2)
         else $fatal(1, "source count must be a power of two");
   end

   for (genvar l = 0; l <= LVLS; l++) begin : lv
      localparam int unsigned CNT = NSRC >> l;
      logic [CNT-1:0]             v;
      logic [CNT-1:0][IDX_W-1:0]  ix;
      logic [CNT-1:0][PRIO_W-1:0] pr;
      if (l == 0) begin : g_leaf
         for (genvar s = 0; s < CNT; s++) begin : g_n
            assign v[s]  = cand[s];
            assign ix[s] = IDX_W'(s);
            assign pr[s] = prio[s];
         end
      end else begin : g_node
         for (genvar n = 0; n < CNT; n++) begin : g_n
            // upper half covers higher source numbers; it wins ties
            logic take_hi;
            assign take_hi = lv[l-1].v[2*n+1] &&
                             (!lv[l-1].v[2*n] || lv[l-1].pr[2*n+1] >= lv[l-1].pr[2*n]);
            assign v[n]  = lv[l-1].v[2*n] | lv[l-1].v[2*n+1];
            assign ix[n] = take_hi ? lv[l-1].ix[2*n+1] : lv[l-1].ix[2*n];
            assign pr[n] = take_hi ? lv[l-1].pr[2*n+1] : lv[l-1].pr[2*n];
         end
      end
   end

   assign hit      = lv[LVLS].v[0];
   assign win_idx  = lv[LVLS].ix[0];
   assign win_prio = lv[LVLS].pr[0];
endmodule

// File: rtl/irq_low_find.sv
module irq_low_find #(
   parameter int unsigned NSRC = 64,
   localparam int unsigned IDX_W = $clog2(NSRC)
) (
   input  logic [NSRC-1:0]  cand,
   output logic             hit,
   output logic [IDX_W-1:0] idx
);
   always_comb begin
      hit = 1'b0;
      idx = '0;
      for (int s = NSRC - 1; s >= 0; s--) begin
         if (cand[s]) begin
            hit = 1'b1;
            idx = IDX_W'(s);
         end
      end
   end
endmodule

// File: rtl/irq_vector_resolver.sv
module irq_vector_resolver
   import irq_vector_pkg::*;
#(
   parameter int unsigned NSRC   = 64,
   parameter int unsigned PRIO_W = 4,
   parameter int unsigned WORD_W = 32,
   localparam int unsigned IDX_W = $clog2(NSRC)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [NSRC-1:0]          pend,
   input  logic [NSRC-1:0]          enab,
   input  logic [NSRC-1:0]          fast_typ,
   input  logic [NSRC*PRIO_W-1:0]   prio_words,
   input  logic                     rd_norm,
   input  logic                     rd_fast,
   output logic [STAT_W-1:0]        norm_word,
   output logic [STAT_W-1:0]        fast_word,
   output logic [NSRC-1:0]          clr_norm,
   output logic [NSRC-1:0]          clr_fast
);
   initial begin
      assert (IDX_W <= STAT_W - IDX_LSB) else $fatal(1, "index field too narrow");
      assert (PRIO_W <= IDX_LSB) else $fatal(1, "priority field too wide");
   end

   logic [NSRC-1:0]             norm_cand, fast_cand;
   logic [NSRC-1:0][PRIO_W-1:0] prio;
   logic                        n_hit, f_hit;
   logic [IDX_W-1:0]            n_idx, f_idx;
   logic [PRIO_W-1:0]           n_prio;

   assign norm_cand = pend & enab & ~fast_typ;
   assign fast_cand = pend & enab & fast_typ;

   irq_prio_unpack #(.NSRC(NSRC), .PRIO_W(PRIO_W), .WORD_W(WORD_W)) u_unpack (
      .words_flat (prio_words),
      .prio       (prio)
   );

   irq_prio_tree #(.NSRC(NSRC), .PRIO_W(PRIO_W)) u_tree (
      .cand     (norm_cand),
      .prio     (prio),
      .hit      (n_hit),
      .win_idx  (n_idx),
      .win_prio (n_prio)
   );

   irq_low_find #(.NSRC(NSRC)) u_fast (
      .cand (fast_cand),
      .hit  (f_hit),
      .idx  (f_idx)
   );

   assign norm_word = n_hit ? {(STAT_W-IDX_LSB)'(n_idx), IDX_LSB'(n_prio)} : NO_CAND;
   assign fast_word = f_hit ? STAT_W'(f_idx) : NO_CAND;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         clr_norm <= '0;
         clr_fast <= '0;
      end else begin
         clr_norm <= (rd_norm && n_hit) ? (NSRC'(1) << n_idx) : '0;
         clr_fast <= (rd_fast && f_hit) ? (NSRC'(1) << f_idx) : '0;
      end
   end

   a_r8_norm_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(clr_norm));
   a_r8_fast_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(clr_fast));
   a_r8_norm_target: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_norm && norm_word != NO_CAND) |=> clr_norm[$past(norm_word[IDX_LSB +: IDX_W])]);
   a_r8_fast_target: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_fast && fast_word != NO_CAND) |=> clr_fast[$past(fast_word[IDX_W-1:0])]);
   a_r9_norm_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_norm || norm_word == NO_CAND) |=> clr_norm == '0);
   a_r9_fast_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_fast || fast_word == NO_CAND) |=> clr_fast == '0);
   a_r3_norm_is_cand: assert property (@(posedge clk) disable iff (!rst_n)
      (norm_word != NO_CAND) |-> norm_cand[norm_word[IDX_LSB +: IDX_W]]);
   a_r6_fast_is_cand: assert property (@(posedge clk) disable iff (!rst_n)
      (fast_word != NO_CAND) |-> fast_cand[fast_word[IDX_W-1:0]]);
endmodule

// File: tb/irq_vector_resolver_bench.sv
module irq_vector_resolver_bench;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [63:0]  pend = '0, enab = '0, fast_typ = '0;
   logic [255:0] prio_words = '0;
   logic         rd_norm = 1'b0, rd_fast = 1'b0;
   logic [31:0]  norm_word, fast_word;
   logic [63:0]  clr_norm, clr_fast;
   int           n_chk = 0, n_bad = 0;
   bit           done = 1'b0;

   always #10 clk = ~clk;

   irq_vector_resolver u_irq_vector_resolver (
      .clk, .rst_n, .pend, .enab, .fast_typ, .prio_words,
      .rd_norm, .rd_fast, .norm_word, .fast_word, .clr_norm, .clr_fast
   );

   task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic set_prio(int n, logic [3:0] p);
      prio_words[4*n +: 4] = p;
   endtask

   function automatic logic [31:0] exp_norm();
      int best = -1, who = -1;
      for (int i = 63; i >= 0; i--)
         if (pend[i] && enab[i] && !fast_typ[i] && int'(prio_words[4*i +: 4]) > best) begin
            best = int'(prio_words[4*i +: 4]);
            who = i;
         end
      return (who < 0) ? 32'hFFFF_FFFF : {16'(who), 16'(best)};
   endfunction

   function automatic logic [31:0] exp_fast();
      for (int i = 0; i < 64; i++)
         if (pend[i] && enab[i] && fast_typ[i]) return 32'(i);
      return 32'hFFFF_FFFF;
   endfunction

   task automatic clear_all();
      @(negedge clk);
      pend = '0; enab = '0; fast_typ = '0; prio_words = '0;
      #2;
   endtask

   // strobe one read, check pulse, drop pending bit like the storage would
   task automatic do_read(bit fast, string tag);
      logic [31:0] w;
      logic [63:0] e;
      w = fast ? exp_fast() : exp_norm();
      e = (w == 32'hFFFF_FFFF) ? '0 : (64'd1 << (fast ? w[5:0] : w[21:16]));
      @(negedge clk);
      if (fast) rd_fast = 1'b1; else rd_norm = 1'b1;
      @(negedge clk);
      rd_fast = 1'b0; rd_norm = 1'b0;
      #2;
      chk({tag, " pulse"}, fast ? clr_fast : clr_norm, e);
      chk({tag, " other pulse idle"}, fast ? clr_norm : clr_fast, '0);
      pend = pend & ~e;
      @(negedge clk); #2;
      chk({tag, " pulse ends"}, fast ? clr_fast : clr_norm, '0);
   endtask

   task automatic t_reset();
      #5;
      chk("R1 clr_norm in reset", clr_norm, '0);
      chk("R1 clr_fast in reset", clr_fast, '0);
      @(negedge clk); rst_n = 1'b1;
      @(negedge clk); #2;
      chk("R1 clr_norm after reset", clr_norm, '0);
      chk("R7 empty normal", norm_word, 32'hFFFF_FFFF);
      chk("R7 empty fast", fast_word, 32'hFFFF_FFFF);
   endtask

   task automatic t_extract();
      clear_all();
      for (int n = 0; n < 64; n++) set_prio(n, 4'(n % 13 + 1));
      pend[13] = 1; enab[13] = 1; #2;
      chk("R2 single source 13", norm_word, exp_norm());
      pend[58] = 1; enab[58] = 1; #2;
      chk("R2 sources 13 and 58", norm_word, exp_norm());
      pend = '1; enab = '1; #2;
      chk("R2 all sources", norm_word, exp_norm());
   endtask

   task automatic t_priority();
      clear_all();
      set_prio(3, 4'd6); set_prio(20, 4'd11); set_prio(47, 4'd14); set_prio(60, 4'd2);
      pend = (64'd1<<3)|(64'd1<<20)|(64'd1<<47)|(64'd1<<60);
      enab = (64'd1<<3)|(64'd1<<20)|(64'd1<<60);
      #2; chk("R3 disabled higher ignored", norm_word, {16'd20, 16'd11});
      enab[47] = 1; fast_typ[47] = 1; #2;
      chk("R3 fast-typed higher ignored", norm_word, {16'd20, 16'd11});
      fast_typ[47] = 0; #2;
      chk("R3 greatest wins", norm_word, {16'd47, 16'd14});
   endtask

   task automatic t_tie();
      clear_all();
      set_prio(5, 4'd7); set_prio(40, 4'd7); set_prio(22, 4'd7); set_prio(61, 4'd3);
      pend = (64'd1<<5)|(64'd1<<40)|(64'd1<<22)|(64'd1<<61); enab = '1; #2;
      chk("R4 tie to highest number", norm_word, {16'd40, 16'd7});
      pend = (64'd1<<0)|(64'd1<<1); #2;
      chk("R4 tie at zero priority", norm_word, {16'd1, 16'd0});
   endtask

   task automatic t_format();
      clear_all();
      set_prio(63, 4'hF); pend[63] = 1; enab[63] = 1; #2;
      chk("R5 field layout", norm_word, 32'h003F_000F);
   endtask

   task automatic t_fast();
      clear_all();
      fast_typ = (64'd1<<50)|(64'd1<<9)|(64'd1<<33)|(64'd1<<2);
      pend = fast_typ; enab = ~(64'd1<<2); #2;
      chk("R6 lowest enabled fast", fast_word, 32'd9);
      chk("R3 fast sources not normal", norm_word, 32'hFFFF_FFFF);
      do_read(1'b1, "R8 fast read");
      chk("R6 next fast after clear", fast_word, 32'd33);
   endtask

   task automatic t_empty();
      clear_all();
      pend = 64'h00F0; #2;
      chk("R7 pending but disabled", norm_word, 32'hFFFF_FFFF);
      do_read(1'b0, "R9 empty normal read");
      do_read(1'b1, "R9 empty fast read");
      enab = 64'h00F0; #2;
      @(negedge clk); @(negedge clk); #2;
      chk("R9 no strobe no pulse", clr_norm, '0);
   endtask

   task automatic t_drain();
      clear_all();
      for (int n = 0; n < 64; n++) set_prio(n, 4'((n * 7) % 16));
      pend = 64'hA5C3_0F11_8421_9E6B; enab = '1; fast_typ = 64'h0000_FFFF_0000_0000;
      for (int k = 0; k < 48; k++) begin
         if (exp_norm() == 32'hFFFF_FFFF) break;
         do_read(1'b0, "R8 normal drain");
      end
      chk("R7 normal drained", norm_word, 32'hFFFF_FFFF);
      for (int k = 0; k < 20; k++) begin
         if (exp_fast() == 32'hFFFF_FFFF) break;
         do_read(1'b1, "R8 fast drain");
      end
      chk("R7 fast drained", fast_word, 32'hFFFF_FFFF);
   endtask

   initial begin
      t_reset();
      t_extract();
      t_priority();
      t_tie();
      t_format();
      t_fast();
      t_empty();
      t_drain();
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (20000) @(posedge clk);
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected done");
         end
      join_any
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule